// File: doc/BRIEF.md
# Vector Byte Table Lookup Unit

This unit performs a byte permutation for a 128-bit vector datapath. Each byte of an index vector selects one byte from a table. The table is built from one to four consecutive vector registers. The unit receives the 32-bit instruction word and decodes it. It reports the register numbers it needs, so that the surrounding register file can return the table registers, the index register and the current destination contents. One clock edge later it presents a registered result.

There are two variants, and both use one datapath. In the zeroing variant, an index that falls outside the table produces a zero byte. In the merge variant, such an index keeps the byte that the destination already held. A narrow form handles only the low eight lanes and clears the upper half of the result. A wide form handles all sixteen lanes. A word that is not a lookup instruction is flagged as illegal. In that case the destination contents pass through unchanged.

The handshake is valid/ready on both sides. A result stays on the outputs until the consumer takes it, and no new request is accepted while a result is waiting.

Top module: `vtbl_unit`

## Requirements
- R1: An instruction word is a lookup only when (instr & 0xBFE08C00) == 0x0E000000. Any other accepted word gives out_illegal=1, and out_result equals the dst_vec that was presented with it.
- R2: The register-number fields sit at fixed positions: rd_sel = instr[4:0] and rm_sel = instr[20:16]. Slot k of tbl_sel (bits 5k+4:5k, k = 0..3) equals (instr[9:5] + k) mod 32, so register 31 is followed by register 0.
- R3: The table has N = instr[14:13] + 1 registers. Byte j of the table is byte (j mod 16) of tbl_data slot j/16, where slot s occupies tbl_data bits 128s+127:128s. Bytes are little-endian within a slot.
- R4: An index byte b that is below 16*N, read as unsigned, is in range. Its result lane receives table byte b.
- R5: With instr[12]=0 (zeroing), an out-of-range index gives a zero result byte. This includes every index of 0x80 or above.
- R6: With instr[12]=1 (merge), an out-of-range index gives the byte of dst_vec in the same lane.
- R7: With instr[30]=0, only lanes 0 to 7 are looked up, and out_result[127:64] is zero in both variants. With instr[30]=1, all 16 lanes are looked up.
- R8: out_valid rises on the edge after in_valid and in_ready are both high. While out_ready is low it stays high, and out_result and out_illegal stay unchanged. It falls after out_ready is seen high, unless a new request is accepted on that edge.
- R9: in_ready is low whenever out_valid is high and out_ready is low.
- R10: After reset, out_valid=0, out_illegal=0 and out_result=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| instr | input | 32 | Instruction word |
| tbl_data | input | 512 | Table registers; slot k is register rn+k |
| idx_vec | input | 128 | Index vector |
| dst_vec | input | 128 | Current destination contents |
| rd_sel | output | 5 | Destination register number |
| tbl_sel | output | 20 | Four table register numbers, wrapped modulo 32 |
| rm_sel | output | 5 | Index register number |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 128 | Registered result vector |
| out_illegal | output | 1 | Accepted word was not a lookup |

## Verification
Several properties are checked on every cycle:
- the handshake rules, meaning a result appears after acceptance, stays stable under backpressure and blocks new requests;
- the clearing of the upper half for narrow accepted lookups;
- the wrap between adjacent table register numbers.

Other behaviour shows only in the bench's scenarios, where each result is compared against an independent lookup model. This covers the byte selection across one to four table registers, the range boundary at 16*N, zeroing versus merging of out-of-range lanes, indices with the top bit set, and the pass-through of illegal words.

// File: rtl/vtbl_pkg.sv
`timescale 1ns/1ps
package vtbl_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned INSTR_W  = 32;
  localparam int unsigned REG_AW   = 5;
  localparam int unsigned LEN_W    = 2;
  localparam int unsigned MAX_REGS = 1 << LEN_W;

  // field positions inside the instruction word
  localparam int unsigned Q_BIT    = 30;
  localparam int unsigned RM_LSB   = 16;
  localparam int unsigned LEN_LSB  = 13;
  localparam int unsigned OP_BIT   = 12;
  localparam int unsigned RN_LSB   = 5;
  localparam int unsigned RD_LSB   = 0;

  // fixed bits of the lookup encoding
  localparam logic [INSTR_W-1:0] MATCH_MASK = 32'hBFE0_8C00;
  localparam logic [INSTR_W-1:0] MATCH_VAL  = 32'h0E00_0000;

  typedef struct packed {
    logic              legal;
    logic              wide;
    logic              merge;
    logic [LEN_W-1:0]  len;
    logic [REG_AW-1:0] rd;
    logic [REG_AW-1:0] rn;
    logic [REG_AW-1:0] rm;
  } tbl_op_t;
endpackage

// File: rtl/vtbl_decode.sv
`timescale 1ns/1ps
module vtbl_decode
  import vtbl_pkg::*;
(
  input  logic [INSTR_W-1:0]         instr,
  output tbl_op_t                    op,
  output logic [MAX_REGS*REG_AW-1:0] tbl_sel
);
  always_comb begin
    op.legal = ((instr & MATCH_MASK) == MATCH_VAL);
    op.wide  = instr[Q_BIT];
    op.merge = instr[OP_BIT];
    op.len   = instr[LEN_LSB +: LEN_W];
    op.rd    = instr[RD_LSB +: REG_AW];
    op.rn    = instr[RN_LSB +: REG_AW];
    op.rm    = instr[RM_LSB +: REG_AW];
  end

  // consecutive table registers, wrapping through the register file
  for (genvar k = 0; k < MAX_REGS; k++) begin : g_sel
    assign tbl_sel[k*REG_AW +: REG_AW] = op.rn + REG_AW'(k);
  end
endmodule

// File: rtl/vtbl_lane.sv
`timescale 1ns/1ps
module vtbl_lane
  import vtbl_pkg::*;
#(
  parameter int unsigned TBL_BYTES = 64,
  parameter int unsigned LIM_W     = 7
) (
  input  logic [TBL_BYTES*BYTE_W-1:0] tbl_bytes,
  input  logic [BYTE_W-1:0]           idx_byte,
  input  logic [BYTE_W-1:0]           dst_byte,
  input  logic [LIM_W-1:0]            limit,
  input  logic                        merge,
  input  logic                        active,
  output logic [BYTE_W-1:0]           res_byte
);
  localparam int unsigned SEL_W = $clog2(TBL_BYTES);

  logic              in_range;
  logic [SEL_W-1:0]  sel;
  logic [BYTE_W-1:0] picked;

  always_comb begin
    in_range = (32'(idx_byte) < 32'(limit));
    sel      = idx_byte[SEL_W-1:0];
    picked   = tbl_bytes[32'(sel)*BYTE_W +: BYTE_W];
    if (!active) begin
      res_byte = '0;
    end else if (in_range) begin
      res_byte = picked;
    end else if (merge) begin
      res_byte = dst_byte;
    end else begin
      res_byte = '0;
    end
  end
endmodule

// File: rtl/vtbl_outreg.sv
`timescale 1ns/1ps
module vtbl_outreg #(
  parameter int unsigned DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              drain,
  input  logic [DATA_W-1:0] d_data,
  input  logic              d_flag,
  output logic              q_valid,
  output logic [DATA_W-1:0] q_data,
  output logic              q_flag
);
  logic valid_nxt;
  logic flag_nxt;

  always_comb begin
    valid_nxt = q_valid;
    flag_nxt  = q_flag;
    if (load) begin
      valid_nxt = 1'b1;
      flag_nxt  = d_flag;
    end else if (drain) begin
      valid_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_flag  <= 1'b0;
    end else begin
      q_valid <= valid_nxt;
      q_flag  <= flag_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_data <= '0;
    end else if (load) begin
      q_data <= d_data;
    end
  end
endmodule

// File: rtl/vtbl_unit.sv
`timescale 1ns/1ps
module vtbl_unit
  import vtbl_pkg::*;
#(
  parameter int unsigned LANES = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              in_valid,
  output logic                              in_ready,
  input  logic [INSTR_W-1:0]                instr,
  input  logic [MAX_REGS*LANES*BYTE_W-1:0]  tbl_data,
  input  logic [LANES*BYTE_W-1:0]           idx_vec,
  input  logic [LANES*BYTE_W-1:0]           dst_vec,
  output logic [REG_AW-1:0]                 rd_sel,
  output logic [MAX_REGS*REG_AW-1:0]        tbl_sel,
  output logic [REG_AW-1:0]                 rm_sel,
  output logic                              out_valid,
  input  logic                              out_ready,
  output logic [LANES*BYTE_W-1:0]           out_result,
  output logic                              out_illegal
);
  localparam int unsigned VEC_W     = LANES * BYTE_W;
  localparam int unsigned TBL_BYTES = LANES * MAX_REGS;
  localparam int unsigned LIM_W     = $clog2(TBL_BYTES) + 1;
  localparam int unsigned HALF      = LANES / 2;

  tbl_op_t            dec;
  logic [LIM_W-1:0]   tbl_limit;
  logic [VEC_W-1:0]   lane_res;
  logic [VEC_W-1:0]   next_result;
  logic               accept;

  vtbl_decode u_decode (
    .instr   (instr),
    .op      (dec),
    .tbl_sel (tbl_sel)
  );

  assign rd_sel = dec.rd;
  assign rm_sel = dec.rm;

  // table length in bytes: (len + 1) registers of LANES bytes
  assign tbl_limit = LIM_W'((32'(dec.len) + 32'd1) * LANES);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    vtbl_lane #(
      .TBL_BYTES (TBL_BYTES),
      .LIM_W     (LIM_W)
    ) u_lane (
      .tbl_bytes (tbl_data),
      .idx_byte  (idx_vec[i*BYTE_W +: BYTE_W]),
      .dst_byte  (dst_vec[i*BYTE_W +: BYTE_W]),
      .limit     (tbl_limit),
      .merge     (dec.merge),
      .active    ((i < HALF) || dec.wide),
      .res_byte  (lane_res[i*BYTE_W +: BYTE_W])
    );
  end

  assign next_result = dec.legal ? lane_res : dst_vec;
  assign in_ready    = !out_valid || out_ready;
  assign accept      = in_valid && in_ready;

  vtbl_outreg #(
    .DATA_W (VEC_W)
  ) u_outreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .drain   (out_ready),
    .d_data  (next_result),
    .d_flag  (!dec.legal),
    .q_valid (out_valid),
    .q_data  (out_result),
    .q_flag  (out_illegal)
  );
endmodule

// File: rtl/vtbl_unit_chk.sv
`timescale 1ns/1ps
module vtbl_unit_chk
  import vtbl_pkg::*;
#(
  parameter int unsigned LANES = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic                       in_ready,
  input logic [INSTR_W-1:0]         instr,
  input logic [MAX_REGS*REG_AW-1:0] tbl_sel,
  input logic                       out_valid,
  input logic                       out_ready,
  input logic [LANES*BYTE_W-1:0]    out_result,
  input logic                       out_illegal
);
  localparam int unsigned VEC_W = LANES * BYTE_W;

  AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R8

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_illegal)); // R8

  AST_DRAIN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid); // R8

  AST_BUSY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R9

  AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !instr[Q_BIT] |=> out_illegal || (out_result[VEC_W-1:VEC_W/2] == '0)); // R7

  AST_SEL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_sel[2*REG_AW-1:REG_AW] == tbl_sel[REG_AW-1:0] + REG_AW'(1)); // R2
endmodule

bind vtbl_unit vtbl_unit_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/vtbl_unit_bench.sv
`timescale 1ns/1ps
module vtbl_unit_bench;
  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [31:0]  instr;
  logic [511:0] tbl_data;
  logic [127:0] idx_vec;
  logic [127:0] dst_vec;
  logic [4:0]   rd_sel;
  logic [19:0]  tbl_sel;
  logic [4:0]   rm_sel;
  logic         out_valid;
  logic         out_ready;
  logic [127:0] out_result;
  logic         out_illegal;

  int total = 0;
  int bad   = 0;

  vtbl_unit u_vtbl_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .instr(instr), .tbl_data(tbl_data), .idx_vec(idx_vec), .dst_vec(dst_vec),
    .rd_sel(rd_sel), .tbl_sel(tbl_sel), .rm_sel(rm_sel),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_illegal(out_illegal)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [128:0] act, input logic [128:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit q, input logic [1:0] len, input bit op,
                                     input logic [4:0] rm, input logic [4:0] rn, input logic [4:0] rd);
    return {1'b0, q, 6'b001110, 3'b000, rm, 1'b0, len, op, 2'b00, rn, rd};
  endfunction

  // independent model: {illegal, result}
  function automatic logic [128:0] model(input logic [31:0] w, input logic [511:0] t,
                                         input logic [127:0] ix, input logic [127:0] d);
    logic [127:0] r;
    int n;
    if ((w & 32'hBFE08C00) != 32'h0E000000) return {1'b1, d};
    n = int'(w[14:13]) + 1;
    r = '0;
    for (int i = 0; i < 16; i++) begin
      int b;
      b = int'(ix[i*8 +: 8]);
      if (i >= 8 && !w[30]) r[i*8 +: 8] = 8'h00;
      else if (b < 16*n)    r[i*8 +: 8] = t[b*8 +: 8];
      else if (w[12])       r[i*8 +: 8] = d[i*8 +: 8];
      else                  r[i*8 +: 8] = 8'h00;
    end
    return {1'b0, r};
  endfunction

  task automatic run_op(input logic [31:0] w, input logic [511:0] t, input logic [127:0] ix,
                        input logic [127:0] d, input int hold, input string tag);
    logic [128:0] e;
    logic [128:0] got;
    e = model(w, t, ix, d);
    @(negedge clk);
    instr = w; tbl_data = t; idx_vec = ix; dst_vec = d;
    in_valid = 1'b1; out_ready = 1'b0;
    #1;
    chk(in_ready, "R9 ready when idle", 129'(in_ready), 129'(1));
    chk(rd_sel == w[4:0] && rm_sel == w[20:16], "R2 rd/rm fields",
        129'({rd_sel, rm_sel}), 129'({w[4:0], w[20:16]}));
    for (int k = 0; k < 4; k++)
      chk(tbl_sel[k*5 +: 5] == 5'(w[9:5] + 5'(k)), "R2 table register wrap",
          129'(tbl_sel[k*5 +: 5]), 129'(5'(w[9:5] + 5'(k))));
    @(negedge clk);
    in_valid = 1'b0;
    got = {out_illegal, out_result};
    chk(out_valid, "R8 valid after accept", 129'(out_valid), 129'(1));
    chk(got == e, tag, got, e);
    chk(!in_ready, "R9 stall while pending", 129'(in_ready), 129'(0));
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(out_valid && {out_illegal, out_result} == e, "R8 hold under backpressure",
          {out_illegal, out_result}, e);
    end
    out_ready = 1'b1;
    @(negedge clk);
    chk(!out_valid, "R8 drop after consume", 129'(out_valid), 129'(0));
    out_ready = 1'b0;
  endtask

  function automatic logic [511:0] rnd_tbl();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [127:0] rnd_vec();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [511:0] pat;
    logic [127:0] ix;
    logic [127:0] dv;
    void'($urandom(32'h00C0FFEE));
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    instr = '0; tbl_data = '0; idx_vec = '0; dst_vec = '0;
    repeat (3) @(negedge clk);
    chk(!out_valid && !out_illegal && out_result == '0, "R10 reset state",
        {out_illegal, out_result}, 129'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && out_result == '0, "R10 after release", 129'(out_valid), 129'(0));

    for (int j = 0; j < 64; j++) pat[j*8 +: 8] = 8'(j) ^ 8'hA5;
    dv = 128'hD0D1D2D3D4D5D6D7D8D9DADBDCDDDEDF;

    // R3 R4: four registers, boundary bytes of each slot
    ix = {8'd63, 8'd48, 8'd47, 8'd32, 8'd31, 8'd16, 8'd15, 8'd0,
          8'd1, 8'd17, 8'd33, 8'd49, 8'd62, 8'd46, 8'd30, 8'd14};
    run_op(mk(1, 2'd3, 0, 5'd2, 5'd1, 5'd0), pat, ix, dv, 0, "R3 R4 four-register layout");

    // R5: two registers, limit 32, zeroing incl. top-bit indices
    ix = {8'd31, 8'd32, 8'h80, 8'hFF, 8'd0, 8'd33, 8'h7F, 8'd16,
          8'd31, 8'd32, 8'h80, 8'hFF, 8'd5, 8'd40, 8'hC0, 8'd17};
    run_op(mk(1, 2'd1, 0, 5'd3, 5'd1, 5'd0), pat, ix, dv, 0, "R5 zeroing out-of-range");

    // R6: same with merge
    run_op(mk(1, 2'd1, 1, 5'd3, 5'd1, 5'd0), pat, ix, dv, 0, "R6 merge keeps destination");

    // R4 R5: single register, limit 16
    ix = {8'd15, 8'd16, 8'd0, 8'd17, 8'd15, 8'd16, 8'd0, 8'd17,
          8'd15, 8'd16, 8'd0, 8'd17, 8'd15, 8'd16, 8'd0, 8'd17};
    run_op(mk(1, 2'd0, 0, 5'd9, 5'd4, 5'd7), pat, ix, dv, 0, "R4 R5 single register limit");

    // R7: narrow merge clears upper half
    run_op(mk(0, 2'd1, 1, 5'd3, 5'd1, 5'd0), pat, ix, dv, 0, "R7 narrow merge upper clear");
    run_op(mk(0, 2'd2, 0, 5'd3, 5'd1, 5'd0), pat, rnd_vec(), dv, 0, "R7 narrow zeroing");

    // R2: wrap of table registers past 31, three-register table
    run_op(mk(1, 2'd3, 0, 5'd30, 5'd31, 5'd29), pat, ix, dv, 0, "R2 R3 wrap at register 31");
    run_op(mk(1, 2'd2, 1, 5'd0, 5'd30, 5'd1), pat, ix, dv, 0, "R3 three-register merge");

    // R1: illegal encodings pass destination through
    run_op(mk(1, 2'd0, 0, 5'd2, 5'd1, 5'd0) | 32'h0000_8000, pat, ix, dv, 0, "R1 illegal bit15");
    run_op(mk(1, 2'd0, 0, 5'd2, 5'd1, 5'd0) | 32'h8000_0000, pat, ix, dv, 0, "R1 illegal bit31");
    run_op(32'hFFFF_FFFF, pat, ix, dv, 1, "R1 illegal all ones");

    // R8: long backpressure
    run_op(mk(1, 2'd3, 1, 5'd2, 5'd1, 5'd0), pat, rnd_vec(), dv, 4, "R8 R6 held result");

    // random mix
    for (int n = 0; n < 300; n++) begin
      logic [31:0]  w;
      logic [127:0] rix;
      if ($urandom % 10 == 0) w = $urandom;
      else w = mk(1'($urandom), 2'($urandom), 1'($urandom), 5'($urandom), 5'($urandom), 5'($urandom));
      rix = rnd_vec();
      if ($urandom % 2 == 0)
        for (int i = 0; i < 16; i++) rix[i*8 +: 8] = 8'($urandom % 72);
      run_op(w, rnd_tbl(), rix, rnd_vec(), int'($urandom % 3), "R1 R4 R5 R6 R7 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule